// File: doc/BRIEF.md
# Embedded-Sync 4:2:2 Video Transmitter

This block takes a stream of 24-bit RGB pixels and turns it into a 16-bit YCbCr 4:2:2 video word per pixel clock. Synchronisation travels inside the data as four-word timing codes, so the block has no separate sync wires. A raster state machine sets the line and frame timing from size inputs held by the surrounding register bank. Each active pixel is taken from a small first-in first-out buffer. That buffer decouples the frame reader from the raster, but it holds far less than a frame.

Each pixel is converted from RGB to studio-range BT.709 YCbCr, and its chroma is then halved by averaging pixel pairs. Two debug paths replace this chain. Bypass passes the low 16 input bits unchanged. Pattern mode fills every active pixel with a captured colour. Output start and pattern mode are driven by control bits that act only on their rising edges.

The raster machine has five states. `ST_IDLE` drives fill words. `ST_SAV` sends the four-word start code. `ST_ACT` covers the active pixel span of `cfg_h_act` words. `ST_EAV` sends the four-word end code. `ST_FILL` covers the rest of the horizontal blanking.

The transitions are:
- start toggle: `ST_IDLE` to `ST_SAV`.
- stop toggle: any state to `ST_IDLE`.
- code done: `ST_SAV` to `ST_ACT`, or `ST_EAV` to `ST_FILL`.
- line done: `ST_ACT` to `ST_EAV`.
- line wrap: `ST_FILL` to `ST_SAV`. The line counter advances here, or returns to 0 after the last line.

Top module: `emb422_tx`

## Requirements
- R1: After reset `vid_out` is the fill word 16'h8010, `uflow` is 0, `in_ready` is 1 and the raster is idle. While idle, `vid_out` stays 16'h8010.
- R2: A rising edge of `en_ctl` starts the raster at line 0 if it is idle, and stops it if it is running. Holding `en_ctl` high or low has no effect. The first start-code word appears on `vid_out` after the fourth rising clock edge, counting the edge that sees `en_ctl` rise.
- R3: Each line has the same layout: 4 start-code words, `cfg_h_act` active words, 4 end-code words, then `cfg_h_blank`-8 fill words of 16'h8010. `cfg_h_blank` must be at least 9 and `cfg_h_act` must be even. A frame has `cfg_v_act` active lines followed by `cfg_v_blank` blanking lines, and then repeats.
- R4: A code is the word sequence 16'hFFFF, 16'h0000, 16'h0000, {XY,XY}. XY = {1, 0, V, H, V^H, H, V, V^H}. H is 0 in the start code and 1 in the end code. V is 1 on blanking lines.
- R5: The input pixel is R=`in_data[23:16]`, G=`[15:8]`, B=`[7:0]`. It is converted as Y=16+((47R+157G+16B+128)>>>8), Cb=128+((-26R-87G+112B+128)>>>8) and Cr=128+((112R-102G-10B+128)>>>8). Each result is clipped to 0..255.
- R6: An active word is {chroma, Y}, with chroma in `vid_out[15:8]`. Pixel positions count from 0 at the start of each active line. An even pixel carries (Cb(i)+Cb(i+1)+1)>>1 and an odd pixel carries (Cr(i-1)+Cr(i)+1)>>1.
- R7: With `cfg_bypass`=1, each active word equals the low 16 bits of its source pixel.
- R8: A rising edge of `pat_ctl` toggles pattern mode. Turning it on captures `cfg_pat_rgb`. In pattern mode every active pixel uses the captured colour and the buffer is not read.
- R9: The buffer holds `FIFO_DEPTH` pixels (default 1024). `in_ready` drops once it is full.
- R10: An active pixel in an active line that finds the buffer empty outside pattern mode is sent as 16'h8010. It also sets `uflow`, which stays set until reset.
- R11: Blanking lines carry fill words in their active span and read no pixel from the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 24 | RGB pixel from the frame reader |
| in_valid | input | 1 | Pixel present on `in_data` |
| in_ready | output | 1 | Buffer can accept a pixel |
| cfg_h_act | input | HW | Active pixels per line |
| cfg_h_blank | input | HW | Horizontal blanking words, both codes included |
| cfg_v_act | input | VW | Active lines per frame |
| cfg_v_blank | input | VW | Blanking lines per frame |
| cfg_bypass | input | 1 | Pass low 16 input bits instead of converting |
| cfg_pat_rgb | input | 24 | Colour captured for pattern mode |
| en_ctl | input | 1 | Start/stop control, rising edge acts |
| pat_ctl | input | 1 | Pattern-mode control, rising edge acts |
| vid_out | output | 16 | 4:2:2 video word with embedded codes |
| uflow | output | 1 | Sticky buffer-underflow flag |

## Verification
The conversion path is driven with black, white, the three primaries and a scrambled ramp. These separate the coefficient signs and the clipping, and the paired averaging shows whether Cb and Cr sit on the right pixel parity. Running past the supplied pixels into a second and third frame produces underflow black and shows that the underflow flag is sticky. The same frame in bypass isolates the timing and code layout from the arithmetic. A pattern frame with an empty buffer shows both that the colour is captured on the edge and that the buffer is never read. Holding and releasing the control bits between frames separates edge action from level action.

// File: rtl/emb422_pkg.sv
package emb422_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAV,
        ST_ACT,
        ST_EAV,
        ST_FILL
    } tx_state_e;

    typedef enum logic [1:0] {
        K_FILL,
        K_CODE,
        K_PIX
    } word_kind_e;

    typedef struct packed {
        word_kind_e  kind;
        logic [15:0] code;
        logic        odd;
        logic        blk;
        logic [7:0]  y;
        logic [7:0]  cb;
        logic [7:0]  cr;
        logic [15:0] raw;
    } pipe_t;

    localparam logic [15:0] FILL_WORD = 16'h8010;

endpackage

// File: rtl/emb422_csc.sv
module emb422_csc (
    input  logic [23:0] rgb,
    output logic [7:0]  y,
    output logic [7:0]  cb,
    output logic [7:0]  cr
);
    function automatic logic [7:0] clip8(input int v);
        if (v < 0)        return 8'd0;
        else if (v > 255) return 8'd255;
        else              return v[7:0];
    endfunction

    int r_i, g_i, b_i;
    int y_acc, cb_acc, cr_acc;

    always_comb begin
        r_i    = int'(rgb[23:16]);
        g_i    = int'(rgb[15:8]);
        b_i    = int'(rgb[7:0]);
        y_acc  = ((47 * r_i + 157 * g_i + 16 * b_i + 128) >>> 8) + 16;
        cb_acc = ((-26 * r_i - 87 * g_i + 112 * b_i + 128) >>> 8) + 128;
        cr_acc = ((112 * r_i - 102 * g_i - 10 * b_i + 128) >>> 8) + 128;
        y      = clip8(y_acc);
        cb     = clip8(cb_acc);
        cr     = clip8(cr_acc);
    end
endmodule

// File: rtl/emb422_fifo.sv
module emb422_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 1024
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count_q <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (rd_en) rd_ptr <= bump(rd_ptr);
            if (wr_en && !rd_en)      count_q <= count_q + CW'(1);
            else if (rd_en && !wr_en) count_q <= count_q - CW'(1);
        end
    end

    assign rd_data = mem[rd_ptr];
    assign full    = (count_q == CW'(DEPTH));
    assign empty   = (count_q == '0);

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    // R10
    no_underread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> count_q != '0);
endmodule

// File: rtl/emb422_raster.sv
module emb422_raster
    import emb422_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tog,
    input  logic [HW-1:0] h_act,
    input  logic [HW-1:0] h_blank,
    input  logic [VW-1:0] v_act,
    input  logic [VW-1:0] v_blank,
    output word_kind_e    kind,
    output logic [15:0]   code,
    output logic          odd,
    output logic          pix
);
    tx_state_e     state_q, state_d;
    logic [HW-1:0] pos_q, pos_d;
    logic [VW-1:0] line_q, line_d;
    logic          last_line, vblank, hflag;
    logic [7:0]    xy;

    assign last_line = ({1'b0, line_q} ==
                        ({1'b0, v_act} + {1'b0, v_blank} - (VW+1)'(1)));

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q + HW'(1);
        line_d  = line_q;
        if (tog) begin
            state_d = (state_q == ST_IDLE) ? ST_SAV : ST_IDLE;
            pos_d   = '0;
            line_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: pos_d = '0;
                ST_SAV: if (pos_q == HW'(3)) begin
                    state_d = ST_ACT;
                    pos_d   = '0;
                end
                ST_ACT: if (pos_q == h_act - HW'(1)) begin
                    state_d = ST_EAV;
                    pos_d   = '0;
                end
                ST_EAV: if (pos_q == HW'(3)) begin
                    state_d = ST_FILL;
                    pos_d   = '0;
                end
                ST_FILL: if (pos_q == h_blank - HW'(9)) begin
                    state_d = ST_SAV;
                    pos_d   = '0;
                    line_d  = last_line ? '0 : line_q + VW'(1);
                end
                default: begin
                    state_d = ST_IDLE;
                    pos_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            line_q  <= line_d;
        end
    end

    always_comb begin
        vblank = (line_q >= v_act);
        hflag  = (state_q == ST_EAV);
        xy     = {1'b1, 1'b0, vblank, hflag, vblank ^ hflag, hflag, vblank, vblank ^ hflag};
        odd    = pos_q[0];
        pix    = 1'b0;
        kind   = K_FILL;
        unique case (pos_q[1:0])
            2'd0:    code = 16'hFFFF;
            2'd3:    code = {xy, xy};
            default: code = 16'h0000;
        endcase
        unique case (state_q)
            ST_SAV, ST_EAV: kind = K_CODE;
            ST_ACT: begin
                kind = vblank ? K_FILL : K_PIX;
                pix  = !vblank;
            end
            default: kind = K_FILL;
        endcase
    end

    // R3
    sav_then_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SAV && pos_q == HW'(3) && !tog) |=> state_q == ST_ACT);
endmodule

// File: rtl/emb422_tx.sv
module emb422_tx
    import emb422_pkg::*;
#(
    parameter int HW         = 12,
    parameter int VW         = 11,
    parameter int FIFO_DEPTH = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [23:0]   in_data,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [HW-1:0] cfg_h_act,
    input  logic [HW-1:0] cfg_h_blank,
    input  logic [VW-1:0] cfg_v_act,
    input  logic [VW-1:0] cfg_v_blank,
    input  logic          cfg_bypass,
    input  logic [23:0]   cfg_pat_rgb,
    input  logic          en_ctl,
    input  logic          pat_ctl,
    output logic [15:0]   vid_out,
    output logic          uflow
);
    logic        en_q, pat_q, start_tog, pat_tog;
    logic        pat_mode;
    logic [23:0] pat_rgb;

    word_kind_e  r_kind;
    logic [15:0] r_code;
    logic        r_odd, r_pix;

    logic        f_full, f_empty, f_rd;
    logic [23:0] f_data, src_rgb;
    logic        take, blk0;
    logic [7:0]  c_y, c_cb, c_cr;

    pipe_t       st0, s1, s2;
    logic [7:0]  prv_cr;
    logic [15:0] word_d;

    assign start_tog = en_ctl & ~en_q;
    assign pat_tog   = pat_ctl & ~pat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            pat_q    <= 1'b0;
            pat_mode <= 1'b0;
            pat_rgb  <= '0;
        end else begin
            en_q  <= en_ctl;
            pat_q <= pat_ctl;
            if (pat_tog) begin
                pat_mode <= ~pat_mode;
                if (!pat_mode) pat_rgb <= cfg_pat_rgb;
            end
        end
    end

    emb422_raster #(.HW(HW), .VW(VW)) i_raster (
        .clk     (clk),
        .rst_n   (rst_n),
        .tog     (start_tog),
        .h_act   (cfg_h_act),
        .h_blank (cfg_h_blank),
        .v_act   (cfg_v_act),
        .v_blank (cfg_v_blank),
        .kind    (r_kind),
        .code    (r_code),
        .odd     (r_odd),
        .pix     (r_pix)
    );

    assign in_ready = ~f_full;
    assign take     = r_pix & ~pat_mode;
    assign f_rd     = take & ~f_empty;
    assign blk0     = take & f_empty;
    assign src_rgb  = pat_mode ? pat_rgb : f_data;

    emb422_fifo #(.W(24), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid & ~f_full),
        .wr_data (in_data),
        .rd_en   (f_rd),
        .rd_data (f_data),
        .full    (f_full),
        .empty   (f_empty)
    );

    emb422_csc i_csc (
        .rgb (src_rgb),
        .y   (c_y),
        .cb  (c_cb),
        .cr  (c_cr)
    );

    always_comb begin
        st0.kind = r_kind;
        st0.code = r_code;
        st0.odd  = r_odd;
        st0.blk  = blk0;
        st0.y    = blk0 ? FILL_WORD[7:0]  : c_y;
        st0.cb   = blk0 ? FILL_WORD[15:8] : c_cb;
        st0.cr   = blk0 ? FILL_WORD[15:8] : c_cr;
        st0.raw  = blk0 ? FILL_WORD : src_rgb[15:0];
    end

    function automatic logic [7:0] avg8(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b} + 9'd1;
        return s[8:1];
    endfunction

    always_comb begin
        unique case (s2.kind)
            K_CODE: word_d = s2.code;
            K_PIX: begin
                if (s2.blk)        word_d = FILL_WORD;
                else if (cfg_bypass) word_d = s2.raw;
                else if (s2.odd)   word_d = {avg8(prv_cr, s2.cr), s2.y};
                else               word_d = {avg8(s2.cb, s1.cb), s2.y};
            end
            default: word_d = FILL_WORD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1      <= '0;
            s2      <= '0;
            prv_cr  <= '0;
            vid_out <= FILL_WORD;
            uflow   <= 1'b0;
        end else begin
            s1      <= st0;
            s2      <= s1;
            prv_cr  <= s2.cr;
            vid_out <= word_d;
            if (blk0) uflow <= 1'b1;
        end
    end

    // R10
    sticky_uflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uflow |=> uflow);
endmodule

// File: tb/test_emb422_tx.sv
module test_emb422_tx;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 12;
    localparam int VW = 11;
    localparam int FDEPTH = 1024;
    localparam int HA = 8;
    localparam int HB = 12;
    localparam int VA = 3;
    localparam int VB = 2;
    localparam int FLEN = (HA + HB) * (VA + VB);

    logic          clk = 1'b0;
    logic          rst_n;
    logic [23:0]   in_data;
    logic          in_valid;
    logic          in_ready;
    logic          cfg_bypass;
    logic [23:0]   cfg_pat_rgb;
    logic          en_ctl, pat_ctl;
    logic [15:0]   vid_out;
    logic          uflow;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q[$];
    int pix_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    emb422_tx #(.HW(HW), .VW(VW), .FIFO_DEPTH(FDEPTH)) i_emb422_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_data     (in_data),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .cfg_h_act   (HW'(HA)),
        .cfg_h_blank (HW'(HB)),
        .cfg_v_act   (VW'(VA)),
        .cfg_v_blank (VW'(VB)),
        .cfg_bypass  (cfg_bypass),
        .cfg_pat_rgb (cfg_pat_rgb),
        .en_ctl      (en_ctl),
        .pat_ctl     (pat_ctl),
        .vid_out     (vid_out),
        .uflow       (uflow)
    );

    task automatic check(input int got, input int exp, input string tag);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int clip8(input int v);
        return (v < 0) ? 0 : (v > 255) ? 255 : v;
    endfunction

    function automatic int code_word(input int vf, input int hf);
        int xy;
        xy = 128 | (vf << 5) | (hf << 4) | ((vf ^ hf) << 3) | (hf << 2) | (vf << 1) | (vf ^ hf);
        return xy * 257;
    endfunction

    task automatic build_frame(input bit byp, input bit pat, input int prgb);
        for (int v = 0; v < VA + VB; v++) begin
            int vf;
            vf = (v >= VA) ? 1 : 0;
            exp_q.push_back('hFFFF); exp_q.push_back(0); exp_q.push_back(0);
            exp_q.push_back(code_word(vf, 0));
            if (vf == 0) begin
                int px[HA];
                int yy[HA];
                int bb[HA];
                int rr[HA];
                for (int i = 0; i < HA; i++) begin
                    int r, g, b;
                    if (pat) px[i] = prgb;
                    else if (pix_q.size() > 0) px[i] = pix_q.pop_front();
                    else px[i] = -1;
                    if (px[i] < 0) begin
                        yy[i] = 16; bb[i] = 128; rr[i] = 128;
                    end else begin
                        r = (px[i] >> 16) & 255; g = (px[i] >> 8) & 255; b = px[i] & 255;
                        yy[i] = clip8(((47 * r + 157 * g + 16 * b + 128) >>> 8) + 16);
                        bb[i] = clip8(((-26 * r - 87 * g + 112 * b + 128) >>> 8) + 128);
                        rr[i] = clip8(((112 * r - 102 * g - 10 * b + 128) >>> 8) + 128);
                    end
                end
                for (int i = 0; i < HA; i++) begin
                    if (px[i] < 0) exp_q.push_back('h8010);
                    else if (byp) exp_q.push_back(px[i] & 'hFFFF);
                    else if (i % 2 == 0) exp_q.push_back((((bb[i] + bb[i+1] + 1) / 2) << 8) | yy[i]);
                    else exp_q.push_back((((rr[i-1] + rr[i] + 1) / 2) << 8) | yy[i]);
                end
            end else begin
                for (int i = 0; i < HA; i++) exp_q.push_back('h8010);
            end
            exp_q.push_back('hFFFF); exp_q.push_back(0); exp_q.push_back(0);
            exp_q.push_back(code_word(vf, 1));
            for (int i = 0; i < HB - 8; i++) exp_q.push_back('h8010);
        end
    endtask

    task automatic compare_n(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(int'(vid_out), exp_q.pop_front(), tag);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; cfg_bypass = 1'b0;
        cfg_pat_rgb = '0; en_ctl = 1'b0; pat_ctl = 1'b0;
        exp_q.delete(); pix_q.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push_px(input int p);
        in_data = p[23:0]; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        pix_q.push_back(p);
    endtask

    task automatic start_raster();
        en_ctl = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        // Conversion, chroma pairing, timing, codes, underflow
        do_reset();
        check(int'(vid_out), 'h8010, "R1 reset word");
        check(int'(uflow), 0, "R1 reset uflow");
        check(int'(in_ready), 1, "R1 reset ready");
        repeat (5) @(negedge clk);
        check(int'(vid_out), 'h8010, "R1 idle word");
        push_px('h000000); push_px('hFFFFFF); push_px('hFF0000); push_px('h00FF00);
        push_px('h0000FF); push_px('hFFFF00); push_px('h808080); push_px('h10EB80);
        for (int i = 8; i < HA * VA; i++) push_px((i * 40503 + 12345) & 'hFFFFFF);
        build_frame(1'b0, 1'b0, 0);
        start_raster();
        compare_n(FLEN, "R2 R3 R4 R5 R6 R11 frame");
        check(int'(uflow), 0, "R10 no underflow yet");
        build_frame(1'b0, 1'b0, 0);
        compare_n(FLEN, "R10 R3 underflow frame");
        check(int'(uflow), 1, "R10 uflow set");
        en_ctl = 1'b0;
        build_frame(1'b0, 1'b0, 0);
        compare_n(FLEN, "R2 level low ignored");
        check(int'(uflow), 1, "R10 uflow sticky");
        en_ctl = 1'b1;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            check(int'(vid_out), 'h8010, "R2 stop toggle idle");
            @(negedge clk);
        end

        // Bypass
        do_reset();
        cfg_bypass = 1'b1;
        for (int i = 0; i < HA * VA; i++) push_px((i * 7919 + 'h5A3C11) & 'hFFFFFF);
        build_frame(1'b1, 1'b0, 0);
        start_raster();
        compare_n(FLEN, "R7 bypass frame");
        check(int'(uflow), 0, "R10 bypass no underflow");

        // Pattern mode with empty buffer
        do_reset();
        cfg_pat_rgb = 24'h3C7AE1;
        pat_ctl = 1'b1;
        @(negedge clk);
        cfg_pat_rgb = 24'h000000;
        build_frame(1'b0, 1'b1, 'h3C7AE1);
        start_raster();
        compare_n(FLEN, "R8 pattern frame");
        check(int'(uflow), 0, "R8 buffer not read");

        // Buffer capacity
        do_reset();
        for (int i = 0; i < FDEPTH; i++) begin
            if (i == FDEPTH - 1) check(int'(in_ready), 1, "R9 ready before full");
            in_data = 24'(i); in_valid = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(int'(in_ready), 0, "R9 full drops ready");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule